// File: doc/BRIEF.md
# Return-to-Zero Serial Word Transmitter

This block turns 32-bit parallel words into a return-to-zero serial stream with its own shift clock. A word comes in through a strobe-and-ready handshake and waits in a one-word holding buffer. When the shifter is free, the word moves in with an odd parity bit added above it, so each message is 33 bits long. The data line leaves bit 0 first. Each bit cell has four equal phases. A one drives the line high for the first two phases only. The shift clock is high in the middle two phases, so its leading edge comes one quarter of a cell after the data edge. The phase length is set by a system-clock divider, and a 200 kbit/s line is reached by picking the divider value for the system clock in use.

The holding buffer lets the next word be accepted while the current one is still on the line. The controller moves through three states. In `ST_IDLE` it waits. It takes the `start` transition to `ST_SHIFT` when the buffer holds a word. The `last_cell` transition leads from `ST_SHIFT` to `ST_DONE`, a one-cycle state that raises the done flag. From `ST_DONE`, `start` goes straight back to `ST_SHIFT` if another word is waiting; otherwise the `drain` transition returns to `ST_IDLE`. A loopback checker reads the line back on each shift-clock rising edge. It recomputes the parity of the 32 data bits and sets a sticky error flag if the result differs from the parity bit that was sent.

Top module: `rz_serial_tx`

## Requirements
- R1: While reset is applied and just after it, ready_o=1 and busy_o, sdata_o, sclk_o, done_o and perr_o are all 0.
- R2: A word on word_i is captured on a clock edge where load_i=1 and ready_o=1. ready_o is 0 from the next cycle while the holding buffer is full. A load_i pulse while ready_o=0 is ignored and its word is never sent.
- R3: A message is 33 bits. Data bit 0 is sent first and data bit 31 thirty-second. Bit 32 is odd parity, so the 33 bits together hold an odd number of ones.
- R4: Each bit cell has four phases, 0 to 3. A 1 bit drives sdata_o high in phases 0 and 1 and low in phases 2 and 3. A 0 bit keeps sdata_o low for the whole cell.
- R5: sclk_o is high in phases 1 and 2 of every cell. Its rising edge therefore comes one phase after the data rising edge, and sdata_o does not change when sclk_o rises.
- R6: Each phase lasts div_i+1 system clocks, so a cell lasts 4*(div_i+1) clocks. div_i is changed only while busy_o=0.
- R7: done_o is a single-cycle pulse that follows the last cell. When a word is loaded at clock edge k into an idle block, done_o is high in the cycle that starts at edge k+1+132*(div_i+1).
- R8: If a word waits in the buffer when a message ends, its first cell starts on the clock after the done cycle and busy_o stays high throughout. A waiting word on an idle block starts on the next clock.
- R9: On each sclk_o rising edge the block samples lb_i. If the inverted XOR of the 32 sampled data bits differs from the parity bit sent, perr_o is set. perr_o stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | 16 | Phase divider: system clocks per phase minus one |
| load_i | input | 1 | Load strobe for word_i |
| word_i | input | 32 | Parallel data word |
| lb_i | input | 1 | Loopback of the serial line for the parity check |
| ready_o | output | 1 | Holding buffer can take a word |
| busy_o | output | 1 | A message is in progress or just finished |
| sdata_o | output | 1 | Return-to-zero serial data |
| sclk_o | output | 1 | Shift clock |
| done_o | output | 1 | One-cycle end-of-message pulse |
| perr_o | output | 1 | Sticky loopback parity error |

## Verification
The assertions assume that div_i stays constant while a message is on the line. They also assume that lb_i changes only in step with the system clock. The bench writes div_i only after done_o has been seen and busy_o is low. It derives lb_i combinationally from sdata_o and flips it for exactly one chosen data bit when it wants to force a parity mismatch. Loads are driven on the falling clock edge, so each strobe covers exactly one rising edge. One of those strobes is deliberately issued while ready_o is low.

// File: rtl/rzt_pkg.sv
package rzt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } tx_state_e;

    localparam int PHASES = 4;
endpackage

// File: rtl/rzt_phase_tick.sv
module rzt_phase_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart_i || cnt >= div_i) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick_o = !restart_i && (cnt >= div_i);
endmodule

// File: rtl/rzt_hold_buf.sv
module rzt_hold_buf #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    input  logic         take_i,
    output logic         full_o,
    output logic [W-1:0] data_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_o <= 1'b0;
            data_o <= '0;
        end else if (take_i) begin
            full_o <= 1'b0;
        end else if (load_i && !full_o) begin
            full_o <= 1'b1;
            data_o <= word_i;
        end
    end
endmodule

// File: rtl/rzt_tx_ctrl.sv
module rzt_tx_ctrl
    import rzt_pkg::*;
#(
    parameter int W     = 32,
    parameter int IDX_W = $clog2(W + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             pend_i,
    input  logic [W-1:0]     pend_data_i,
    output logic             start_o,
    output logic             samp_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             cur_bit_o,
    output logic             sdata_o,
    output logic             sclk_o,
    output logic             done_o,
    output logic             busy_o
);
    localparam int FRAME = W + 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME - 1);
    localparam logic [1:0] LAST_PH = 2'(PHASES - 1);

    tx_state_e      state, state_nx;
    logic [1:0]     ph;
    logic [IDX_W-1:0] idx;
    logic [W:0]     shreg;
    logic           start, last_cell;

    assign start     = (state != ST_SHIFT) && pend_i;
    assign last_cell = (state == ST_SHIFT) && tick_i && (ph == LAST_PH) && (idx == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)     state_nx = ST_SHIFT;
            ST_SHIFT: if (last_cell) state_nx = ST_DONE;
            ST_DONE:  state_nx = start ? ST_SHIFT : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph    <= '0;
            idx   <= '0;
            shreg <= '0;
        end else if (start) begin
            ph    <= '0;
            idx   <= '0;
            shreg <= {~^pend_data_i, pend_data_i};
        end else if (state == ST_SHIFT && tick_i) begin
            ph <= ph + 1'b1;
            if (ph == LAST_PH) begin
                idx   <= idx + 1'b1;
                shreg <= shreg >> 1;
            end
        end
    end

    always_comb begin
        start_o   = start;
        idx_o     = idx;
        cur_bit_o = shreg[0];
        samp_o    = 1'b0;
        sdata_o   = 1'b0;
        sclk_o    = 1'b0;
        done_o    = 1'b0;
        busy_o    = 1'b1;
        unique case (state)
            ST_IDLE:  busy_o = 1'b0;
            ST_SHIFT: begin
                sdata_o = shreg[0] && !ph[1];
                sclk_o  = (ph == 2'd1) || (ph == 2'd2);
                samp_o  = tick_i && (ph == 2'd0);
            end
            ST_DONE:  done_o = 1'b1;
            default:  busy_o = 1'b0;
        endcase
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (idx <= LAST_IDX)); // R3
endmodule

// File: rtl/rzt_loop_chk.sv
module rzt_loop_chk #(
    parameter int W     = 32,
    parameter int IDX_W = $clog2(W + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             samp_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             sent_i,
    input  logic             lb_i,
    output logic             perr_o
);
    localparam logic [IDX_W-1:0] PAR_IDX = IDX_W'(W);

    logic acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= 1'b0;
            perr_o <= 1'b0;
        end else if (start_i) begin
            acc <= 1'b0;
        end else if (samp_i) begin
            if (idx_i < PAR_IDX) begin
                acc <= acc ^ lb_i;
            end else if (idx_i == PAR_IDX && (~acc != sent_i)) begin
                perr_o <= 1'b1;
            end
        end
    end

    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |=> perr_o); // R9
endmodule

// File: rtl/rz_serial_tx.sv
module rz_serial_tx #(
    parameter int W     = 32,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             load_i,
    input  logic [W-1:0]     word_i,
    input  logic             lb_i,
    output logic             ready_o,
    output logic             busy_o,
    output logic             sdata_o,
    output logic             sclk_o,
    output logic             done_o,
    output logic             perr_o
);
    localparam int IDX_W = $clog2(W + 2);

    logic             tick, start, samp, pend, cur_bit;
    logic [W-1:0]     pend_data;
    logic [IDX_W-1:0] idx;

    rzt_phase_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart_i(start), .div_i(div_i), .tick_o(tick)
    );

    rzt_hold_buf #(.W(W)) u_hold (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .word_i(word_i),
        .take_i(start), .full_o(pend), .data_o(pend_data)
    );

    rzt_tx_ctrl #(.W(W), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .pend_i(pend),
        .pend_data_i(pend_data), .start_o(start), .samp_o(samp), .idx_o(idx),
        .cur_bit_o(cur_bit), .sdata_o(sdata_o), .sclk_o(sclk_o),
        .done_o(done_o), .busy_o(busy_o)
    );

    rzt_loop_chk #(.W(W), .IDX_W(IDX_W)) u_chk (
        .clk(clk), .rst_n(rst_n), .start_i(start), .samp_i(samp), .idx_i(idx),
        .sent_i(cur_bit), .lb_i(lb_i), .perr_o(perr_o)
    );

    assign ready_o = !pend;

    AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && ready_o) |=> !ready_o); // R2
    AST_RZ_LOW_AT_CLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> !sdata_o); // R4
    AST_DATA_STABLE_AT_CLK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(sdata_o)); // R5
    AST_PENDING_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !busy_o) |=> busy_o); // R8
endmodule

// File: tb/tb_rz_serial_tx.sv
`timescale 1ns/1ps
module tb_rz_serial_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] div_i = 16'd1;
    logic        load_i = 1'b0;
    logic [31:0] word_i = '0;
    logic        lb_i;
    logic        ready_o, busy_o, sdata_o, sclk_o, done_o, perr_o;

    int n_chk = 0, n_fail = 0;
    bit flip_en = 1'b0;

    int cyc = 0, rx_n = 0, t_drise = 0, t_crise = 0;
    int last_skew = -1, last_chigh = -1, last_dhigh = -1, rz_bad = 0, busy_lows = 0;
    logic rx_bits [0:65];
    logic p_sdata = 1'b0, p_sclk = 1'b0;

    always #4 clk = ~clk;

    assign lb_i = sdata_o ^ (flip_en && rx_n == 5);

    rz_serial_tx dut (
        .clk(clk), .rst_n(rst_n), .div_i(div_i), .load_i(load_i), .word_i(word_i),
        .lb_i(lb_i), .ready_o(ready_o), .busy_o(busy_o), .sdata_o(sdata_o),
        .sclk_o(sclk_o), .done_o(done_o), .perr_o(perr_o)
    );

    always @(negedge clk) begin
        cyc++;
        if (!busy_o) busy_lows++;
        if (sdata_o && !p_sdata) t_drise = cyc;
        if (!sdata_o && p_sdata) last_dhigh = cyc - t_drise;
        if (sclk_o && !p_sclk) begin
            if (rx_n < 66) rx_bits[rx_n] = sdata_o;
            rx_n++;
            t_crise = cyc;
            if (sdata_o) last_skew = cyc - t_drise;
        end
        if (!sclk_o && p_sclk) begin
            last_chigh = cyc - t_crise;
            if (sdata_o) rz_bad++;
        end
        p_sdata = sdata_o;
        p_sclk  = sclk_o;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [32:0] frame_of(input logic [31:0] w);
        return {~^w, w};
    endfunction

    function automatic logic [32:0] got_frame(input int base);
        logic [32:0] f;
        for (int i = 0; i < 33; i++) f[i] = rx_bits[base + i];
        return f;
    endfunction

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done_o && lat < 20000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic t_reset;
        chk("R1 ready", ready_o, 1);
        chk("R1 busy", busy_o, 0);
        chk("R1 sdata", sdata_o, 0);
        chk("R1 sclk", sclk_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 perr", perr_o, 0);
    endtask

    task automatic t_single(input logic [31:0] w, input logic [15:0] dv);
        int lat;
        @(negedge clk);
        div_i = dv;
        rx_n = 0; rz_bad = 0; last_skew = -1; last_chigh = -1; last_dhigh = -1;
        @(negedge clk);
        load_i = 1'b1; word_i = w;
        @(negedge clk);
        load_i = 1'b0;
        chk("R2 ready low while held", ready_o, 0);
        wait_done(lat);
        lat++;
        chk("R7 latency", lat, 2 + 132 * (dv + 1));
        @(negedge clk);
        chk("R7 done one cycle", done_o, 0);
        chk("R3 bit count", rx_n, 33);
        chk("R3 frame", got_frame(0), frame_of(w));
        chk("R4 rz low at clk fall", rz_bad, 0);
        chk("R4 data high width", last_dhigh, 2 * (dv + 1));
        chk("R5 clock skew", last_skew, dv + 1);
        chk("R6 clock high width", last_chigh, 2 * (dv + 1));
        chk("R8 back to idle", busy_o, 0);
    endtask

    task automatic t_buffered;
        logic [31:0] a = 32'h1234_5678, b = 32'h8000_00FE, c = 32'hDEAD_BEEF;
        int lat, gap;
        @(negedge clk);
        div_i = 16'd0; rx_n = 0;
        load_i = 1'b1; word_i = a;
        @(negedge clk);
        load_i = 1'b0;
        @(negedge clk);
        chk("R2 ready after transfer", ready_o, 1);
        busy_lows = 0;
        load_i = 1'b1; word_i = b;
        @(negedge clk);
        chk("R2 ready low with pending", ready_o, 0);
        word_i = c;
        @(negedge clk);
        load_i = 1'b0;
        wait_done(lat);
        @(negedge clk);
        gap = 1;
        wait_done(lat);
        gap += lat;
        chk("R8 next done spacing", gap, 133);
        chk("R8 busy held", busy_lows, 0);
        @(negedge clk);
        chk("R3 first frame", got_frame(0), frame_of(a));
        chk("R2 ignored load, second frame", got_frame(33), frame_of(b));
        chk("R2 total bits", rx_n, 66);
    endtask

    task automatic t_parity;
        int lat;
        chk("R9 clean so far", perr_o, 0);
        @(negedge clk);
        div_i = 16'd0; rx_n = 0; flip_en = 1'b1;
        load_i = 1'b1; word_i = 32'h0F0F_1234;
        @(negedge clk);
        load_i = 1'b0;
        wait_done(lat);
        @(negedge clk);
        flip_en = 1'b0;
        chk("R9 error flagged", perr_o, 1);
        t_single(32'h0000_0003, 16'd0);
        chk("R9 sticky", perr_o, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single(32'hA5C3_0F01, 16'd1);
        t_single(32'h0000_0000, 16'd3);
        t_single(32'hFFFF_FFFF, 16'd0);
        t_buffered();
        t_parity();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule